// File: doc/BRIEF.md
# Cumulative-Threshold Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the live raster position, a vertical-blanking flag and a programmable line event. It runs on the pixel clock. Software does not program each phase as a separate duration. For each axis it writes running sums measured from the start of sync: sync length minus one, then that value plus the back porch, then that plus the active size, then that plus the front porch. The generator compares its pixel and line counters against these thresholds directly.

A small write/read register port holds the thresholds, a control word and the line-event position. The control word carries the run bit, one polarity bit for each of the three strobes, and a flag that asks the panel side to use the opposite pixel-clock edge. A two-state machine sequences the generator. It moves from `ST_OFF` to `ST_SCAN` on the first clock edge that sees the run bit set, and from `ST_SCAN` to `ST_OFF` on the first edge that sees it clear. Each axis is decoded into one of four phases: `PH_SYNC`, `PH_BACK`, `PH_ACTIVE` and `PH_FRONT`.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset every register reads zero and the generator is stopped. `pos_h` and `pos_v` are 0. `hsync`, `vsync` and `de` sit high, which is their inactive level under the default low-active polarity. `line_evt`, `vblank` and `pclk_inv` are 0.
- R2: Register slots are selected by `reg_addr`. Slot 0 holds the sync values, slot 1 the accumulated back porch, slot 2 the accumulated active value and slot 3 the total. Slot 4 is control and slot 5 is the line-event position. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational and return only the implemented bits; all other bits and unmapped slots read 0.
- R3: In each timing slot the horizontal value sits in bits 27:16 and the vertical value in bits 10:0. Slot 5 uses bits 10:0.
- R4: Control bit 0 is the run bit. While it is clear, or in the first cycle after it is set, every strobe rests at its inactive level, `pos_h`, `pos_v`, `line_evt` and `vblank` are 0, and the counters are held at 0. Scanning begins at position (0,0) on the second clock edge after the enabling write.
- R5: While scanning, the pixel counter advances by one each cycle from 0 up to the horizontal total inclusive, then returns to 0 and steps the line counter. The line counter returns to 0 after the vertical total.
- R6: Sync is active while its counter is at or below that axis's sync value.
- R7: With ordered thresholds, `de` is active exactly when the pixel counter is above the horizontal back-porch sum and at or below the horizontal active sum, and the line counter is likewise inside its own back-porch and active range.
- R8: Control bits 31, 30 and 29 make `hsync`, `vsync` and `de` respectively active high; clear bits make them active low. The inactive level follows the same bit while stopped.
- R9: `pclk_inv` mirrors control bit 28 whether or not the generator runs.
- R10: `line_evt` pulses for one cycle while scanning, at pixel 0 of the line equal to the slot 5 value. It never fires when that value exceeds the vertical total.
- R11: While scanning, `vblank` is 1 whenever the line counter is outside the vertical active range (above the back-porch sum, at or below the active sum).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register slot select for write and read |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Combinational read data of the selected slot |
| hsync | output | 1 | Horizontal sync, polarity per control bit 31 |
| vsync | output | 1 | Vertical sync, polarity per control bit 30 |
| de | output | 1 | Data enable, polarity per control bit 29 |
| pclk_inv | output | 1 | Request to drive panel data on the opposite clock edge |
| line_evt | output | 1 | One-cycle line event pulse |
| vblank | output | 1 | Vertical blanking status |
| pos_h | output | HW (12) | Current pixel counter |
| pos_v | output | VW (11) | Current line counter |

## Verification
The bench builds the generator with its default widths: 12-bit pixel counter, 11-bit line counter, 3-bit slot address and 32-bit data. Software-style writes then program totals of only a few pixels and lines, so a full frame lasts under a hundred cycles. That makes the pixel wrap, the line wrap at the last line, a line event on line 0, and an event position beyond the frame all reachable in every configuration. It also lets one-cycle phases, such as a single-pixel sync or a back porch of one, be checked on every cycle. Full-ones writes exercise the field masking of the 12-bit and 11-bit slices.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

    typedef enum logic {
        ST_OFF,
        ST_SCAN
    } scan_state_t;

    typedef enum logic [1:0] {
        PH_SYNC,
        PH_BACK,
        PH_ACTIVE,
        PH_FRONT
    } phase_t;

    // register slot numbers
    localparam int unsigned SLOT_SYNC    = 0;
    localparam int unsigned SLOT_BPORCH  = 1;
    localparam int unsigned SLOT_ACTIVE  = 2;
    localparam int unsigned SLOT_TOTAL   = 3;
    localparam int unsigned SLOT_CTRL    = 4;
    localparam int unsigned SLOT_LINE    = 5;
    localparam int unsigned TIMING_SLOTS = 4;

    // field placement inside a timing slot
    localparam int unsigned H_LSB = 16;

    // control bit positions
    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_PCLK = 28;
    localparam int unsigned BIT_DE   = 29;
    localparam int unsigned BIT_VS   = 30;
    localparam int unsigned BIT_HS   = 31;

endpackage

// File: rtl/dtg_regs.sv
`timescale 1ns/1ps
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 32,
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      addr,
    input  logic [DW-1:0]                      wdata,
    output logic [DW-1:0]                      rdata,
    output logic [TIMING_SLOTS-1:0][HW-1:0]    h_fld,
    output logic [TIMING_SLOTS-1:0][VW-1:0]    v_fld,
    output logic [VW-1:0]                      lpos,
    output logic                               run_bit,
    output logic                               pol_hs,
    output logic                               pol_vs,
    output logic                               pol_de,
    output logic                               pclk_flip
);

    localparam int unsigned SW = $clog2(TIMING_SLOTS);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // one storage slot per cumulative threshold pair
    for (genvar i = 0; i < TIMING_SLOTS; i++) begin : g_slot
        logic [HW-1:0] h_q;
        logic [VW-1:0] v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                h_q <= '0;
                v_q <= '0;
            end else if (wr_en && addr == AW'(i)) begin
                h_q <= wdata[H_LSB +: HW];
                v_q <= wdata[VW-1:0];
            end
        end
        assign h_fld[i] = h_q;
        assign v_fld[i] = v_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_bit   <= 1'b0;
            pol_hs    <= 1'b0;
            pol_vs    <= 1'b0;
            pol_de    <= 1'b0;
            pclk_flip <= 1'b0;
        end else if (wr_en && addr == AW'(SLOT_CTRL)) begin
            run_bit   <= wdata[BIT_RUN];
            pol_hs    <= wdata[BIT_HS];
            pol_vs    <= wdata[BIT_VS];
            pol_de    <= wdata[BIT_DE];
            pclk_flip <= wdata[BIT_PCLK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lpos <= '0;
        end else if (wr_en && addr == AW'(SLOT_LINE)) begin
            lpos <= wdata[VW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(SLOT_CTRL)) begin
            rdata[BIT_RUN]  = run_bit;
            rdata[BIT_PCLK] = pclk_flip;
            rdata[BIT_DE]   = pol_de;
            rdata[BIT_VS]   = pol_vs;
            rdata[BIT_HS]   = pol_hs;
        end else if (addr == AW'(SLOT_LINE)) begin
            rdata[VW-1:0] = lpos;
        end else if (addr < AW'(TIMING_SLOTS)) begin
            rdata[H_LSB +: HW] = h_fld[addr[SW-1:0]];
            rdata[VW-1:0]      = v_fld[addr[SW-1:0]];
        end
    end

endmodule

// File: rtl/dtg_scan.sv
`timescale 1ns/1ps
module dtg_scan
    import dtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_bit,
    input  logic [HW-1:0] tot_h,
    input  logic [VW-1:0] tot_v,
    output scan_state_t   state,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt
);

    scan_state_t state_nxt;
    logic        advance;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:  if (run_bit)  state_nxt = ST_SCAN;
            ST_SCAN: if (!run_bit) state_nxt = ST_OFF;
        endcase
    end

    // counters move only when scanning and still enabled
    always_comb begin
        advance = 1'b0;
        unique case (state)
            ST_OFF:  advance = 1'b0;
            ST_SCAN: advance = run_bit;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (!advance) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == tot_h) begin
            hcnt <= '0;
            vcnt <= (vcnt == tot_v) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/dtg_decode.sv
`timescale 1ns/1ps
module dtg_decode
    import dtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input  logic          run,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic [HW-1:0] h_sync,
    input  logic [HW-1:0] h_bp,
    input  logic [HW-1:0] h_act,
    input  logic [VW-1:0] v_sync,
    input  logic [VW-1:0] v_bp,
    input  logic [VW-1:0] v_act,
    input  logic [VW-1:0] lpos,
    input  logic          pol_hs,
    input  logic          pol_vs,
    input  logic          pol_de,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          line_evt,
    output logic          vblank
);

    phase_t hph, vph;
    logic   hs_on, vs_on, h_win, v_win;

    // threshold compare: first threshold not yet passed names the phase
    always_comb begin
        if      (hcnt <= h_sync) hph = PH_SYNC;
        else if (hcnt <= h_bp)   hph = PH_BACK;
        else if (hcnt <= h_act)  hph = PH_ACTIVE;
        else                     hph = PH_FRONT;

        if      (vcnt <= v_sync) vph = PH_SYNC;
        else if (vcnt <= v_bp)   vph = PH_BACK;
        else if (vcnt <= v_act)  vph = PH_ACTIVE;
        else                     vph = PH_FRONT;
    end

    always_comb begin
        hs_on = 1'b0;
        h_win = 1'b0;
        unique case (hph)
            PH_SYNC:           hs_on = 1'b1;
            PH_ACTIVE:         h_win = 1'b1;
            PH_BACK, PH_FRONT: ;
        endcase
        vs_on = 1'b0;
        v_win = 1'b0;
        unique case (vph)
            PH_SYNC:           vs_on = 1'b1;
            PH_ACTIVE:         v_win = 1'b1;
            PH_BACK, PH_FRONT: ;
        endcase
    end

    // pin levels: active level equals the polarity bit
    always_comb begin
        hsync    = (run && hs_on)          ? pol_hs : ~pol_hs;
        vsync    = (run && vs_on)          ? pol_vs : ~pol_vs;
        de       = (run && h_win && v_win) ? pol_de : ~pol_de;
        line_evt = run && (hcnt == '0) && (vcnt == lpos);
        vblank   = run && !v_win;
    end

endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int unsigned AW = 3,
    parameter int unsigned DW = 32,
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pclk_inv,
    output logic          line_evt,
    output logic          vblank,
    output logic [HW-1:0] pos_h,
    output logic [VW-1:0] pos_v
);

    logic [TIMING_SLOTS-1:0][HW-1:0] h_fld;
    logic [TIMING_SLOTS-1:0][VW-1:0] v_fld;
    logic [VW-1:0]                   lpos;
    logic                            run_bit, pol_hs, pol_vs, pol_de;
    scan_state_t                     state;
    logic [HW-1:0]                   hcnt, tot_h;
    logic [VW-1:0]                   vcnt;
    logic                            run;

    assign tot_h = h_fld[SLOT_TOTAL];

    dtg_regs #(.AW(AW), .DW(DW), .HW(HW), .VW(VW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .h_fld     (h_fld),
        .v_fld     (v_fld),
        .lpos      (lpos),
        .run_bit   (run_bit),
        .pol_hs    (pol_hs),
        .pol_vs    (pol_vs),
        .pol_de    (pol_de),
        .pclk_flip (pclk_inv)
    );

    dtg_scan #(.HW(HW), .VW(VW)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_bit (run_bit),
        .tot_h   (tot_h),
        .tot_v   (v_fld[SLOT_TOTAL]),
        .state   (state),
        .hcnt    (hcnt),
        .vcnt    (vcnt)
    );

    assign run   = (state == ST_SCAN) && run_bit;
    assign pos_h = run ? hcnt : '0;
    assign pos_v = run ? vcnt : '0;

    dtg_decode #(.HW(HW), .VW(VW)) u_decode (
        .run      (run),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .h_sync   (h_fld[SLOT_SYNC]),
        .h_bp     (h_fld[SLOT_BPORCH]),
        .h_act    (h_fld[SLOT_ACTIVE]),
        .v_sync   (v_fld[SLOT_SYNC]),
        .v_bp     (v_fld[SLOT_BPORCH]),
        .v_act    (v_fld[SLOT_ACTIVE]),
        .lpos     (lpos),
        .pol_hs   (pol_hs),
        .pol_vs   (pol_vs),
        .pol_de   (pol_de),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .line_evt (line_evt),
        .vblank   (vblank)
    );

endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
module dtg_checker #(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_bit,
    input logic          run,
    input logic [HW-1:0] tot_h,
    input logic [HW-1:0] pos_h,
    input logic [VW-1:0] pos_v,
    input logic          line_evt,
    input logic          vblank,
    input logic          de,
    input logic          pol_de
);

    // R4
    stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_bit |-> (pos_h == '0 && pos_v == '0 && !line_evt && !vblank));

    // R5
    pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pos_h != tot_h) |=> (!run_bit || pos_h == HW'($past(pos_h) + 1'b1)));

    // R5
    pixel_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pos_h == tot_h) |=> (!run_bit || pos_h == '0));

    // R10
    line_evt_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt |-> (run && pos_h == '0));

    // R11
    de_outside_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && de == pol_de) |-> !vblank);

endmodule

bind disp_timing_gen dtg_checker #(.HW(HW), .VW(VW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_bit  (run_bit),
    .run      (run),
    .tot_h    (tot_h),
    .pos_h    (pos_h),
    .pos_v    (pos_v),
    .line_evt (line_evt),
    .vblank   (vblank),
    .de       (de),
    .pol_de   (pol_de)
);

// File: tb/disp_timing_gen_bench.sv
`timescale 1ns/1ps
module disp_timing_gen_bench;

    localparam int unsigned AW = 3;
    localparam int unsigned DW = 32;
    localparam int unsigned HW = 12;
    localparam int unsigned VW = 11;

    typedef struct packed {
        logic [11:0] hs, hb, ha, ht;
        logic [10:0] vs, vb, va, vt;
        logic [3:0]  pol;   // [3]=hsync [2]=vsync [1]=de [0]=pclk
        logic [10:0] lp;
    } cfg_t;

    localparam int NVEC = 3;
    localparam cfg_t VEC [NVEC] = '{
        '{12'd1, 12'd4, 12'd9, 12'd11, 11'd1, 11'd2, 11'd5, 11'd7, 4'b0000, 11'd6},
        '{12'd0, 12'd1, 12'd6, 12'd8,  11'd0, 11'd1, 11'd4, 11'd5, 4'b1111, 11'd0},
        '{12'd2, 12'd3, 12'd4, 12'd5,  11'd1, 11'd1, 11'd3, 11'd4, 4'b1010, 11'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          hsync, vsync, de, pclk_inv, line_evt, vblank;
    logic [HW-1:0] pos_h;
    logic [VW-1:0] pos_v;

    int nvec = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    disp_timing_gen #(.AW(AW), .DW(DW), .HW(HW), .VW(VW)) u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .pclk_inv(pclk_inv), .line_evt(line_evt),
        .vblank(vblank), .pos_h(pos_h), .pos_v(pos_v)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input int a, input logic [DW-1:0] d);
        reg_wr    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [DW-1:0] exp, input string req);
        reg_addr = AW'(a);
        #1;
        chk(reg_rdata == exp, req, "readback", int'(reg_rdata), int'(exp));
    endtask

    task automatic idle_chk(input logic [3:0] pol, input string req);
        chk(pos_h == '0 && pos_v == '0, req, "idle position", int'({pos_v, pos_h}), 0);
        chk(hsync == ~pol[3], req, "idle hsync", int'(hsync), int'(~pol[3]));
        chk(vsync == ~pol[2], req, "idle vsync", int'(vsync), int'(~pol[2]));
        chk(de == ~pol[1], req, "idle de", int'(de), int'(~pol[1]));
        chk(!line_evt && !vblank, req, "idle event/blank", int'({line_evt, vblank}), 0);
        chk(pclk_inv == pol[0], "R9", "pclk_inv", int'(pclk_inv), int'(pol[0]));
    endtask

    initial begin : watchdog
        #1000000;
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin : main
        int eh, ev;
        logic e_hs, e_vs, e_de, e_ev, e_vb, e_vin;
        cfg_t c;
        int ncyc;

        repeat (3) @(negedge clk);
        // R1: reset state
        idle_chk(4'b0000, "R1");
        for (int a = 0; a < 6; a++) rd_chk(a, 32'h0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk(4'b0000, "R1");

        // R2, R3: field masking and placement
        wr(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'h0FFF_07FF, "R3");
        wr(5, 32'hFFFF_FFFF);
        rd_chk(5, 32'h0000_07FF, "R3");
        wr(4, 32'hFFFF_FFFE);
        rd_chk(4, 32'hF000_0000, "R2");
        rd_chk(6, 32'h0, "R2");
        // R8 inactive levels follow polarity while stopped, R9 pclk flag while stopped
        idle_chk(4'b1111, "R8");

        // vector table walk
        for (int k = 0; k < NVEC; k++) begin
            c = VEC[k];
            wr(4, {c.pol, 27'd0, 1'b0});
            idle_chk(c.pol, "R8");
            wr(0, {4'd0, c.hs, 5'd0, c.vs});
            wr(1, {4'd0, c.hb, 5'd0, c.vb});
            wr(2, {4'd0, c.ha, 5'd0, c.va});
            wr(3, {4'd0, c.ht, 5'd0, c.vt});
            wr(5, {21'd0, c.lp});
            rd_chk(2, {4'd0, c.ha, 5'd0, c.va}, "R2");
            wr(4, {c.pol, 27'd0, 1'b1});
            // first cycle after the enabling write: still idle
            idle_chk(c.pol, "R4");
            @(negedge clk);
            eh = 0;
            ev = 0;
            ncyc = (int'(c.ht) + 1) * (int'(c.vt) + 1) + (int'(c.ht) + 1) * 2 + 3;
            for (int n = 0; n < ncyc; n++) begin
                e_hs  = (eh <= int'(c.hs));
                e_vs  = (ev <= int'(c.vs));
                e_vin = (ev > int'(c.vb)) && (ev <= int'(c.va));
                e_de  = (eh > int'(c.hb)) && (eh <= int'(c.ha)) && e_vin;
                e_ev  = (eh == 0) && (ev == int'(c.lp));
                e_vb  = !e_vin;
                chk(int'(pos_h) == eh, "R5", "pos_h", int'(pos_h), eh);
                chk(int'(pos_v) == ev, "R5", "pos_v", int'(pos_v), ev);
                chk(hsync == (c.pol[3] ? e_hs : !e_hs), "R6", "hsync", int'(hsync), int'(c.pol[3] ? e_hs : !e_hs));
                chk(vsync == (c.pol[2] ? e_vs : !e_vs), "R6", "vsync", int'(vsync), int'(c.pol[2] ? e_vs : !e_vs));
                chk(de == (c.pol[1] ? e_de : !e_de), "R7", "de", int'(de), int'(c.pol[1] ? e_de : !e_de));
                chk(pclk_inv == c.pol[0], "R9", "pclk_inv", int'(pclk_inv), int'(c.pol[0]));
                chk(line_evt == e_ev, "R10", "line_evt", int'(line_evt), int'(e_ev));
                chk(vblank == e_vb, "R11", "vblank", int'(vblank), int'(e_vb));
                if (eh == int'(c.ht)) begin
                    eh = 0;
                    ev = (ev == int'(c.vt)) ? 0 : ev + 1;
                end else begin
                    eh = eh + 1;
                end
                @(negedge clk);
            end
        end

        // R4: stopping mid-frame returns everything to idle at once
        c = VEC[NVEC-1];
        wr(4, {c.pol, 27'd0, 1'b0});
        idle_chk(c.pol, "R4");
        @(negedge clk);
        idle_chk(c.pol, "R4");

        // R1: a second reset clears registers
        rst_n = 1'b0;
        #1;
        rd_chk(3, 32'h0, "R1");
        rd_chk(4, 32'h0, "R1");
        idle_chk(4'b0000, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule